// File: doc/BRIEF.md
# Status Register with Edge-Filtered Event Capture

This block holds one level of a hierarchical status-reporting tree. A vector of live condition bits comes in, either from hardware flags or from the summary outputs of lower-level instances. Each bit passes through two programmable filters, one for 0-to-1 changes and one for 1-to-0 changes. A change that passes a filter sets a sticky event bit.

Software reads the event register, and that read clears it. An enable register selects which event bits count towards a single registered summary output. The summary output is meant to be wired into one condition input of a parent instance, so that a single low-level event can ripple up the hierarchy.

Access is through a small synchronous register port. It has an address, a write strobe with write data, and a read strobe. Read data is registered and appears one cycle after the strobe.

Top module: `status_reg`

## Requirements
- R1: After reset, the rising-capture mask reads all ones. The falling-capture mask, the enable register and the event register read zero, and the summary output is 0.
- R2: A read at address 0 returns the condition input as it was in the read cycle. A write to address 0 changes nothing.
- R3: When a condition bit changes from 0 to 1 between consecutive clocks, its event bit is set if and only if the rising-capture mask bit (address 1) is 1.
- R4: When a condition bit changes from 1 to 0 between consecutive clocks, its event bit is set if and only if the falling-capture mask bit (address 2) is 1.
- R5: Event bits stay set until the event register (address 3) is read. That read returns the current value and then clears every event bit.
- R6: An edge that passes a filter in the same cycle as an event read sets its event bit after the clear. The read returns the value from before that edge.
- R7: A write to the event register address has no effect on the event bits.
- R8: The two capture masks and the enable register (address 4) read back the last value written. Reading them changes nothing.
- R9: The summary output equals the OR over all bits of (event AND enable), delayed by one clock after those registers change.
- R10: Addresses 5 to 7 read as zero, and writes to them change no register.
- R11: No edge is captured on the first clock after reset, whatever level the condition input holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cond_in | input | WIDTH | Live condition vector, synchronous to clk |
| addr | input | 3 | Register select: 0 condition, 1 rising mask, 2 falling mask, 3 event, 4 enable |
| wr_en | input | 1 | Write strobe |
| wr_data | input | WIDTH | Write data |
| rd_en | input | 1 | Read strobe; a read at address 3 clears the events |
| rd_data | output | WIDTH | Registered read data, valid one cycle after rd_en |
| summary | output | 1 | Registered OR of enabled event bits |

## Verification
A wrong stored previous condition, or a wrong mask bit, shows up at the next event read as an extra or missing bit in exactly one position. This makes the sweep over all four filter settings per bit pinpoint the faulty bit. A broken clear-on-read, or a lost edge during a read, shows in the second of two back-to-back event reads. A summary path with the wrong latency or the wrong masking is wrong at the port exactly one clock after an event or enable change, which is where the bench samples it.

// File: rtl/status_reg_pkg.sv
package status_reg_pkg;
  localparam int AW = 3;

  typedef enum logic [AW-1:0] {
    SEL_COND = 3'd0,
    SEL_RISE = 3'd1,
    SEL_FALL = 3'd2,
    SEL_EVT  = 3'd3,
    SEL_EN   = 3'd4
  } sel_t;

  // bits that passed either filter
  function automatic logic [63:0] filt_edges(input logic [63:0] rise, input logic [63:0] fall,
                                             input logic [63:0] rmask, input logic [63:0] fmask);
    return (rise & rmask) | (fall & fmask);
  endfunction

  // sticky update with clear-on-read; new edges win over the clear
  function automatic logic [63:0] evt_update(input logic [63:0] cur, input logic clr,
                                             input logic [63:0] setv);
    return (clr ? 64'd0 : cur) | setv;
  endfunction
endpackage

// File: rtl/sr_edge_detect.sv
module sr_edge_detect #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] cond_in,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);
  logic [WIDTH-1:0] cond_q;
  logic             primed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cond_q <= '0;
      primed <= 1'b0;
    end else begin
      cond_q <= cond_in;
      primed <= 1'b1;
    end
  end

  assign rise = primed ? (cond_in & ~cond_q) : '0;
  assign fall = primed ? (~cond_in & cond_q) : '0;

  // R3
  rise_then_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((cond_q & $past(rise)) == $past(rise)));
endmodule

// File: rtl/sr_event_store.sv
module sr_event_store #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_bits,
  input  logic             clr_all,
  output logic [WIDTH-1:0] evt
);
  import status_reg_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) evt <= '0;
    else        evt <= WIDTH'(evt_update(64'(evt), clr_all, 64'(set_bits)));
  end

  // R5
  evt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_all |=> ((evt & $past(evt)) == $past(evt)));
  // R5
  evt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_all && set_bits == '0) |=> (evt == '0));
  // R3
  evt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((evt & ~$past(evt) & ~$past(set_bits)) == '0));
  // R6
  evt_survive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> ((evt & $past(set_bits)) == $past(set_bits)));
endmodule

// File: rtl/sr_summary.sv
module sr_summary #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] evt,
  input  logic [WIDTH-1:0] en,
  output logic             sum_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) sum_q <= 1'b0;
    else        sum_q <= |(evt & en);
  end

  // R9
  sum_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt & en) == '0) |=> !sum_q);
  // R9
  sum_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt & en) != '0) |=> sum_q);
endmodule

// File: rtl/status_reg.sv
module status_reg #(
  parameter int WIDTH = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [WIDTH-1:0]              cond_in,
  input  logic [status_reg_pkg::AW-1:0] addr,
  input  logic                          wr_en,
  input  logic [WIDTH-1:0]              wr_data,
  input  logic                          rd_en,
  output logic [WIDTH-1:0]              rd_data,
  output logic                          summary
);
  import status_reg_pkg::*;

  logic [WIDTH-1:0] rmask, fmask, en_r, evt, rise, fall, set_bits;
  logic             clr_all;

  sr_edge_detect #(.WIDTH(WIDTH)) u_edge (
    .clk(clk), .rst_n(rst_n), .cond_in(cond_in), .rise(rise), .fall(fall));

  assign set_bits = WIDTH'(filt_edges(64'(rise), 64'(fall), 64'(rmask), 64'(fmask)));
  assign clr_all  = rd_en && (addr == SEL_EVT);

  sr_event_store #(.WIDTH(WIDTH)) u_evt (
    .clk(clk), .rst_n(rst_n), .set_bits(set_bits), .clr_all(clr_all), .evt(evt));

  sr_summary #(.WIDTH(WIDTH)) u_sum (
    .clk(clk), .rst_n(rst_n), .evt(evt), .en(en_r), .sum_q(summary));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rmask <= '1;
      fmask <= '0;
      en_r  <= '0;
    end else if (wr_en) begin
      case (addr)
        SEL_RISE: rmask <= wr_data;
        SEL_FALL: fmask <= wr_data;
        SEL_EN:   en_r  <= wr_data;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else if (rd_en) begin
      case (addr)
        SEL_COND: rd_data <= cond_in;
        SEL_RISE: rd_data <= rmask;
        SEL_FALL: rd_data <= fmask;
        SEL_EVT:  rd_data <= evt;
        SEL_EN:   rd_data <= en_r;
        default:  rd_data <= '0;
      endcase
    end
  end

  // R8
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(rmask) && $stable(fmask) && $stable(en_r)));
endmodule

// File: tb/status_reg_test.sv
module status_reg_test;
  localparam int W = 16;
  logic clk = 0, rst_n = 0;
  logic [W-1:0] cond_in = '0, wr_data = '0;
  logic [2:0] addr = '0;
  logic wr_en = 0, rd_en = 0;
  logic [W-1:0] rd_data;
  logic summary;
  int checks = 0, fails = 0;
  bit done = 0;

  logic [W-1:0] m_rm, m_fm, m_en, m_evt, m_prev, got;

  always #2 clk = ~clk;

  status_reg #(.WIDTH(W)) uut (.clk(clk), .rst_n(rst_n), .cond_in(cond_in), .addr(addr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .summary(summary));

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    addr = a; wr_data = d; wr_en = 1; step(); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
    addr = a; rd_en = 1; step(); d = rd_data; rd_en = 0;
  endtask

  function automatic logic [W-1:0] captured(input logic [W-1:0] o, input logic [W-1:0] n,
                                            input logic [W-1:0] rm, input logic [W-1:0] fm);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++)
      r[i] = (o[i] == 0 && n[i] == 1 && rm[i]) || (o[i] == 1 && n[i] == 0 && fm[i]);
    return r;
  endfunction

  task automatic apply(input logic [W-1:0] v);
    cond_in = v; step();
    m_evt = m_evt | captured(m_prev, v, m_rm, m_fm);
    m_prev = v;
  endtask

  task automatic sweep(input string req, input logic [W-1:0] seed);
    logic [W-1:0] v = seed;
    for (int k = 0; k < 24; k++) begin
      v = {v[W-2:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
      apply(v);
      if (k % 3 == 2) begin
        rd(3'd3, got); check(req, got, m_evt); m_evt = '0;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    cond_in = '1;
    repeat (3) step();
    rst_n = 1;
    m_rm = '1; m_fm = '0; m_en = '0; m_evt = '0; m_prev = '1;
    check("R1 summary", {15'd0, summary}, '0);
    step(); step();
    rd(3'd1, got); check("R1 rise mask", got, '1);
    rd(3'd2, got); check("R1 fall mask", got, '0);
    rd(3'd4, got); check("R1 enable", got, '0);
    rd(3'd3, got); check("R11/R1 event after reset with high inputs", got, '0);

    // R8 readback, twice to show no side effect
    m_rm = 16'hAAAA; m_fm = 16'hCCCC; m_en = 16'h00F0;
    wr(3'd1, m_rm); wr(3'd2, m_fm); wr(3'd4, m_en);
    for (int t = 0; t < 2; t++) begin
      rd(3'd1, got); check("R8 rise mask", got, m_rm);
      rd(3'd2, got); check("R8 fall mask", got, m_fm);
      rd(3'd4, got); check("R8 enable", got, m_en);
    end

    // R2 condition read and write ignored
    cond_in = 16'h5A3C; step(); m_prev = 16'h5A3C;
    m_evt = m_evt | captured(16'hFFFF, 16'h5A3C, m_rm, m_fm);
    wr(3'd0, 16'h1234);
    rd(3'd0, got); check("R2 condition read", got, 16'h5A3C);
    rd(3'd3, got); check("R4 falling capture", got, m_evt); m_evt = '0;

    // R3/R4 sweep over all four filter settings per bit
    wr(3'd4, '0); m_en = '0;
    sweep("R3/R4 mixed filters", 16'hACE1);
    m_rm = 16'h5555; m_fm = 16'h3333; wr(3'd1, m_rm); wr(3'd2, m_fm);
    sweep("R3/R4 swapped filters", 16'h1F2B);
    m_rm = '0; m_fm = '0; wr(3'd1, m_rm); wr(3'd2, m_fm);
    sweep("R3/R4 none captured", 16'h7777);
    m_rm = '1; m_fm = '1; wr(3'd1, m_rm); wr(3'd2, m_fm);
    sweep("R3/R4 both captured", 16'h0BAD);

    // R5 sticky across idle cycles, then clear
    apply(16'h0000); rd(3'd3, got); m_evt = '0;
    apply(16'h0101); repeat (5) step();
    rd(3'd3, got); check("R5 sticky read", got, 16'h0101);
    rd(3'd3, got); check("R5 cleared after read", got, '0);

    // R7 event not writable
    apply(16'h0000);
    wr(3'd3, 16'hFFFF);
    rd(3'd3, got); check("R7 event write ignored", got, 16'h0101);

    // R6 edge in read cycle survives
    apply(16'h0003); m_evt = 16'h0003;
    addr = 3'd3; rd_en = 1; cond_in = 16'h0013; step(); rd_en = 0;
    check("R6 read returns old value", rd_data, 16'h0003);
    rd(3'd3, got); check("R6 new edge survives clear", got, 16'h0010);

    // R9 summary latency and masking
    m_en = 16'h0100; wr(3'd4, m_en);
    apply(16'h0002);
    check("R9 masked event no summary", {15'd0, summary}, '0);
    apply(16'h0102);
    check("R9 summary not yet", {15'd0, summary}, '0);
    step();
    check("R9 summary after one clock", {15'd0, summary}, 16'd1);
    rd(3'd3, got);
    check("R9 summary holds in read cycle", {15'd0, summary}, 16'd1);
    step();
    check("R9 summary drops after clear", {15'd0, summary}, '0);

    // R10 unused addresses
    wr(3'd5, 16'h0F0F); wr(3'd6, 16'hF0F0); wr(3'd7, 16'hFFFF);
    for (int a = 5; a < 8; a++) begin
      rd(3'(a), got); check("R10 unused read zero", got, '0);
    end
    rd(3'd1, got); check("R10 rise mask unchanged", got, m_rm);
    rd(3'd2, got); check("R10 fall mask unchanged", got, m_fm);
    rd(3'd4, got); check("R10 enable unchanged", got, m_en);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule